// File: doc/BRIEF.md
# Auto Low-Power Read Controller

This block sits beside the array of a parallel read memory and decides, cycle by cycle, whether the data bus is driven and which power state the device reports. It samples an active-low chip select, an active-low read enable and the word address on every clock edge. Its registered outputs appear one edge after the inputs they follow.

A read access counts as complete once select and read enable have been low for `ACC_CYC` consecutive sampling edges with no address change. When an access completes, the block drops into a near-standby state. It stays there until a new address arrives or a control edge starts another read. That wake-up re-enters the active state at the same one-edge latency as any other input, and the new access is timed exactly like a fresh one. No penalty cycle is added.

After reset, the block comes up with chip select possibly held low. Entry into the low-power state is then withheld until the address first changes or chip select is released.

Top module: `alp_read_ctrl`

## Requirements
- R1: `bus_drive` is 1 one edge after an edge that sampled `chip_sel_n`=0 and `rd_en_n`=0; otherwise it is 0 one edge later.
- R2: Whenever `chip_sel_n` is sampled high, `pwr_state` is 2'b10 (standby) after that edge. During and straight out of reset, `pwr_state` is 2'b10 and `bus_drive` is 0.
- R3: With select and read enable low, `pwr_state` becomes 2'b01 (auto low power) after the `ACC_CYC`-th consecutive such edge. The count starts at the edge that starts the access and requires an unchanged address. Before that edge, `pwr_state` is 2'b00 (active).
- R4: From 2'b01, an address change or a falling edge on `chip_sel_n` or `rd_en_n` gives 2'b00 after that edge. Low power returns after another `ACC_CYC` edges, the same count as a fresh access.
- R5: After reset, auto low power is never entered while `chip_sel_n` stays low and the address is unchanged. The first address change or the first high on `chip_sel_n` lifts this block permanently.
- R6: Raising `rd_en_n` while in 2'b01 with select still low leaves `pwr_state` at 2'b01 and clears `bus_drive`.
- R7: An address change or a high `rd_en_n` before the `ACC_CYC`-th edge restarts the access count, so `pwr_state` stays 2'b00 until a full uninterrupted access completes.
- R8: `pwr_state` only takes the codes 00, 01 and 10. A high `chip_sel_n` wins over a simultaneous wake event, giving 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Active-low device select |
| rd_en_n | input | 1 | Active-low read / output enable |
| addr | input | ADDR_W | Word address |
| bus_drive | output | 1 | 1 = data pins driven, 0 = high impedance |
| pwr_state | output | 2 | 00 active, 01 auto low power, 10 standby |

## Verification
Both outputs are registered once. The result for the inputs sampled at one rising edge is visible from just after that edge. Low-power entry is due right after the `ACC_CYC`-th edge of an uninterrupted access. The bench drives each input set on a falling edge and queues the outputs it expects. A monitor pops one entry 1 ns after every rising edge, so each expectation is compared exactly one edge after its stimulus. The sequences cover the power-up hold, the release of that hold by address and by select, wake-ups by address, by read enable and by select, and restarts in the middle of an access.

// File: rtl/alp_pkg.sv
package alp_pkg;

   typedef enum logic [1:0] {
      PWR_ACTIVE  = 2'b00,
      PWR_LOWPWR  = 2'b01,
      PWR_STANDBY = 2'b10
   } pwr_t;

endpackage

// File: rtl/alp_edge_detect.sv
module alp_edge_detect #(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_sel_n,
   input  logic              rd_en_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              addr_chg,
   output logic              ctl_start
);

   logic              primed;
   logic              sel_q;
   logic              rd_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed <= 1'b0;
         sel_q  <= 1'b1;
         rd_q   <= 1'b1;
         addr_q <= '0;
      end else begin
         primed <= 1'b1;
         sel_q  <= chip_sel_n;
         rd_q   <= rd_en_n;
         addr_q <= addr;
      end
   end

   // events are meaningful only once one real sample is held
   assign addr_chg  = primed && (addr != addr_q);
   assign ctl_start = primed && ((sel_q && !chip_sel_n) || (rd_q && !rd_en_n));

endmodule

// File: rtl/alp_access_timer.sv
module alp_access_timer #(
   parameter int ACC_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reading,
   input  logic restart,
   output logic acc_done
);

   localparam int CNT_W = (ACC_CYC < 2) ? 1 : $clog2(ACC_CYC + 1);
   localparam logic [CNT_W-1:0] ACC_MAX = CNT_W'(ACC_CYC);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   generate
      if (ACC_CYC == 1) begin : g_single
         // one selected edge already completes the access
         assign acc_done = reading;
      end else begin : g_count
         logic [CNT_W-1:0] cnt;
         logic [CNT_W-1:0] cnt_nx;

         always_comb begin
            if (!reading)
               cnt_nx = '0;
            else if (restart)
               cnt_nx = ONE;
            else if (cnt == ACC_MAX)
               cnt_nx = ACC_MAX;
            else
               cnt_nx = cnt + ONE;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else
               cnt <= cnt_nx;
         end

         assign acc_done = reading && (cnt_nx == ACC_MAX);

         assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= ACC_MAX);
         assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !reading |=> cnt == '0);
      end
   endgenerate

endmodule

// File: rtl/alp_power_fsm.sv
module alp_power_fsm
   import alp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic chip_sel_n,
   input  logic wake,
   input  logic addr_chg,
   input  logic acc_done,
   output pwr_t state
);

   pwr_t state_nx;
   logic hold_off;
   logic hold_off_nx;

   always_comb begin
      if (chip_sel_n)
         state_nx = PWR_STANDBY;
      else if (wake)
         state_nx = PWR_ACTIVE;
      else if (state == PWR_LOWPWR)
         state_nx = PWR_LOWPWR;
      else if (acc_done && !hold_off)
         state_nx = PWR_LOWPWR;
      else
         state_nx = PWR_ACTIVE;
   end

   // power-up hold lifts on the first address move or deselect
   assign hold_off_nx = hold_off && !chip_sel_n && !addr_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= PWR_STANDBY;
         hold_off <= 1'b1;
      end else begin
         state    <= state_nx;
         hold_off <= hold_off_nx;
      end
   end

   assert_deselect_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
      chip_sel_n |=> state == PWR_STANDBY);
   assert_wake_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PWR_LOWPWR && wake && !chip_sel_n) |=> state == PWR_ACTIVE);
   assert_powerup_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_off && !chip_sel_n && !addr_chg) |=> state != PWR_LOWPWR);
   assert_legal_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      state != 2'b11);

endmodule

// File: rtl/alp_read_ctrl.sv
module alp_read_ctrl
   import alp_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int ACC_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_sel_n,
   input  logic              rd_en_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              bus_drive,
   output logic [1:0]        pwr_state
);

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("alp_read_ctrl: ADDR_W must be at least 1");
      end
      if (ACC_CYC < 1) begin : g_bad_acc
         $error("alp_read_ctrl: ACC_CYC must be at least 1");
      end
   endgenerate

   logic addr_chg;
   logic ctl_start;
   logic wake;
   logic reading;
   logic acc_done;
   pwr_t state;

   alp_edge_detect #(.ADDR_W(ADDR_W)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .chip_sel_n (chip_sel_n),
      .rd_en_n    (rd_en_n),
      .addr       (addr),
      .addr_chg   (addr_chg),
      .ctl_start  (ctl_start)
   );

   assign wake    = addr_chg || ctl_start;
   assign reading = !chip_sel_n && !rd_en_n;

   alp_access_timer #(.ACC_CYC(ACC_CYC)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .reading  (reading),
      .restart  (wake),
      .acc_done (acc_done)
   );

   alp_power_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .chip_sel_n (chip_sel_n),
      .wake       (wake),
      .addr_chg   (addr_chg),
      .acc_done   (acc_done),
      .state      (state)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_drive <= 1'b0;
      else
         bus_drive <= reading;
   end

   assign pwr_state = state;

   assert_drive_not_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive |-> pwr_state != PWR_STANDBY);

endmodule

// File: tb/tb_alp_read_ctrl.sv
`timescale 1ns/1ps
module tb_alp_read_ctrl;

   localparam int AW  = 8;
   localparam int ACC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chip_sel_n = 1'b0;
   logic          rd_en_n = 1'b0;
   logic [AW-1:0] addr = 8'h10;
   logic          bus_drive;
   logic [1:0]    pwr_state;

   typedef struct {
      logic [1:0] pwr;
      logic       drv;
      string      req;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   always #2 clk = ~clk;

   alp_read_ctrl #(.ADDR_W(AW), .ACC_CYC(ACC)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .chip_sel_n (chip_sel_n),
      .rd_en_n    (rd_en_n),
      .addr       (addr),
      .bus_drive  (bus_drive),
      .pwr_state  (pwr_state)
   );

   task automatic check(input logic [1:0] p, input logic d, input string req);
      n_chk++;
      if (pwr_state !== p || bus_drive !== d) begin
         n_bad++;
         $display("FAIL %s: pwr=%b drv=%b expected pwr=%b drv=%b", req, pwr_state, bus_drive, p, d);
      end
   endtask

   // driver: apply one input set on a falling edge, queue the outcome
   task automatic step(input logic cs, input logic re, input logic [AW-1:0] a,
                       input logic [1:0] p, input logic d, input string req);
      exp_t e;
      @(negedge clk);
      chip_sel_n = cs;
      rd_en_n    = re;
      addr       = a;
      e.pwr = p;
      e.drv = d;
      e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic do_reset(input logic cs, input logic re, input logic [AW-1:0] a);
      @(negedge clk);
      rst_n      = 1'b0;
      chip_sel_n = cs;
      rd_en_n    = re;
      addr       = a;
      repeat (2) @(negedge clk);
      check(2'b10, 1'b0, "R2 reset");
      rst_n = 1'b1;
   endtask

   // monitor: one result due per rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.pwr, e.drv, e.req);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
   end

   initial begin
      do_reset(1'b0, 1'b0, 8'h10);
      // R5: held selected from power-up, no low power
      for (int i = 0; i < 8; i++) step(0, 0, 8'h10, 2'b00, 1, "R5 hold");
      // R3: address move lifts hold, full access then low power
      step(0, 0, 8'h11, 2'b00, 1, "R3");
      step(0, 0, 8'h11, 2'b00, 1, "R3");
      step(0, 0, 8'h11, 2'b00, 1, "R3");
      step(0, 0, 8'h11, 2'b01, 1, "R3 entry");
      step(0, 0, 8'h11, 2'b01, 1, "R3 stay");
      // R6: read enable released inside low power
      step(0, 1, 8'h11, 2'b01, 0, "R6");
      step(0, 1, 8'h11, 2'b01, 0, "R6");
      // R4: read enable falls again
      step(0, 0, 8'h11, 2'b00, 1, "R4 rd wake");
      step(0, 0, 8'h11, 2'b00, 1, "R4");
      step(0, 0, 8'h11, 2'b00, 1, "R4");
      step(0, 0, 8'h11, 2'b01, 1, "R4 reentry");
      // R4: address wake
      step(0, 0, 8'h22, 2'b00, 1, "R4 addr wake");
      step(0, 0, 8'h22, 2'b00, 1, "R4");
      step(0, 0, 8'h22, 2'b00, 1, "R4");
      step(0, 0, 8'h22, 2'b01, 1, "R4 reentry");
      // R7: address change mid access restarts count
      step(0, 0, 8'h33, 2'b00, 1, "R7");
      step(0, 0, 8'h33, 2'b00, 1, "R7");
      step(0, 0, 8'h34, 2'b00, 1, "R7 restart");
      step(0, 0, 8'h34, 2'b00, 1, "R7");
      step(0, 0, 8'h34, 2'b00, 1, "R7");
      step(0, 0, 8'h34, 2'b01, 1, "R7 done");
      // R7: read enable high mid access
      step(0, 0, 8'h40, 2'b00, 1, "R7");
      step(0, 0, 8'h40, 2'b00, 1, "R7");
      step(0, 1, 8'h40, 2'b00, 0, "R7 R1 rd off");
      step(0, 0, 8'h40, 2'b00, 1, "R7");
      step(0, 0, 8'h40, 2'b00, 1, "R7");
      step(0, 0, 8'h40, 2'b00, 1, "R7");
      step(0, 0, 8'h40, 2'b01, 1, "R7 done");
      // R8: deselect wins over a simultaneous address change
      step(1, 0, 8'h55, 2'b10, 0, "R8 priority");
      step(1, 0, 8'h55, 2'b10, 0, "R2 standby");
      // R4: select falls
      step(0, 0, 8'h55, 2'b00, 1, "R4 cs wake");
      step(0, 0, 8'h55, 2'b00, 1, "R4");
      step(0, 0, 8'h55, 2'b00, 1, "R4");
      step(0, 0, 8'h55, 2'b01, 1, "R4 reentry");
      // R1: selected but not reading
      step(0, 1, 8'h60, 2'b00, 0, "R1");
      step(0, 1, 8'h60, 2'b00, 0, "R1");
      repeat (3) @(posedge clk);
      // R5: second power-up, hold lifted by deselect
      do_reset(1'b0, 1'b0, 8'h70);
      for (int i = 0; i < 6; i++) step(0, 0, 8'h70, 2'b00, 1, "R5 hold");
      step(1, 0, 8'h70, 2'b10, 0, "R5 R2 deselect");
      step(0, 0, 8'h70, 2'b00, 1, "R5");
      step(0, 0, 8'h70, 2'b00, 1, "R5");
      step(0, 0, 8'h70, 2'b00, 1, "R5");
      step(0, 0, 8'h70, 2'b01, 1, "R5 lifted");
      repeat (3) @(posedge clk);
      #2;
      finish_run();
   end

endmodule